// File: doc/BRIEF.md
# Stream-to-memory write packer

This block sits on the write side of a DMA destination. A narrow stream delivers 16-bit words, and the block gathers them into 64-bit memory beats. Each beat leaves with its data and one strobe bit per byte lane. A transfer opens with a command that carries a start address and a byte count.

The start address must sit on a memory-word boundary. The byte count only has to be a whole number of stream words. When the count does not fill the last memory word, that beat goes out as soon as its final stream word arrives. Its strobes then cover only the bytes that hold data, so memory past the end of the transfer is never written. Commands that break these rules are refused with a one-cycle error pulse, and the block stays idle.

Control is a three-state machine:
- **Idle** accepts commands.
- **Fill** takes stream words into the byte lanes, lowest lane first.
- **Send** presents the packed beat.

The transitions are:
- *accept*: Idle to Fill, on a valid command.
- *reject*: Idle to Idle, with the error pulse.
- *beat complete*: Fill to Send, when the lanes are full or the last word arrives.
- *continue*: Send to Fill, when a non-final beat is taken.
- *finish*: Send to Idle, when the final beat is taken.

Top module: `s2m_pack`

## Requirements
- R1: A command whose address is not a multiple of 8 is refused. `cmd_err` is high for exactly one cycle, in the cycle after the command handshake. `cmd_ready` stays high and no beat is produced.
- R2: A command whose byte length is zero or odd is refused in the same way as in R1. Any nonzero even length is accepted, including lengths that are not multiples of 8.
- R3: The final beat carries `m_strb` bit i set if and only if i < (len - 8*(number of earlier beats)). The set bits are therefore contiguous from bit 0.
- R4: Every beat other than the final one has all 8 strobe bits set.
- R5: Stream word k of a beat (k = 0..3, in arrival order) appears in `m_data[16k+15:16k]` and sets `m_strb[2k+1:2k]`. Lanes that receive no word read as zero.
- R6: A transfer of len bytes yields exactly ceil(len/8) beats, and `m_last` is high on the final beat only.
- R7: In the cycle after the final beat is taken, `cmd_ready` is high and `m_valid` is low.
- R8: While `m_valid` is high and `m_ready` is low, `m_data`, `m_strb` and `m_last` hold their values, and `s_ready` stays low while a beat is pending.
- R9: Out of reset, and after each finish, only `cmd_ready` is high. In the cycle after an accepted command, only `s_ready` is high. `cmd_ready`, `s_ready` and `m_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken (Idle) |
| cmd_addr | input | 32 | Transfer start byte address |
| cmd_len | input | 16 | Transfer length in bytes |
| cmd_err | output | 1 | One-cycle pulse after a refused command |
| s_valid | input | 1 | Stream word offered |
| s_ready | output | 1 | Stream word taken (Fill) |
| s_data | input | 16 | Stream word |
| m_valid | output | 1 | Memory beat offered (Send) |
| m_ready | input | 1 | Memory beat taken |
| m_data | output | 64 | Packed beat data |
| m_strb | output | 8 | Byte-lane write strobes |
| m_last | output | 1 | Final beat of the transfer |

## Verification
The assertions assume the stream side supplies exactly len/2 words per accepted command and keeps each word stable until it is taken. The command fields are assumed to matter only in the handshake cycle. The stimulus keeps to these assumptions by sending exactly the computed word count, with random idle gaps between words. It also drops `m_ready` at random, which exercises the hold behaviour. Refused commands are mixed in between transfers, and the stream stays quiet until the next accepted command.

// File: rtl/s2m_pack_pkg.sv
package s2m_pack_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_SEND = 2'd2
    } pack_state_t;
endpackage

// File: rtl/s2m_cmd_check.sv
module s2m_cmd_check #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int MEM_B  = 8,
    parameter int STR_B  = 2
)(
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic              ok
);
    localparam logic [ADDR_W-1:0] ADDR_MASK = ADDR_W'(MEM_B - 1);
    localparam logic [LEN_W-1:0]  LEN_MASK  = LEN_W'(STR_B - 1);

    logic addr_ok;
    logic len_ok;

    always_comb begin
        addr_ok = (addr & ADDR_MASK) == '0;
        len_ok  = ((len & LEN_MASK) == '0) && (len != '0);
        ok      = addr_ok && len_ok;
    end
endmodule

// File: rtl/s2m_lane_buf.sv
module s2m_lane_buf #(
    parameter int STR_W  = 16,
    parameter int RATIO  = 4,
    parameter int LANE_W = 2
)(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   wr_en,
    input  logic [LANE_W-1:0]      lane_sel,
    input  logic [STR_W-1:0]       din,
    output logic [STR_W*RATIO-1:0] data,
    output logic [STR_W/8*RATIO-1:0] strb
);
    localparam int STR_B = STR_W / 8;

    for (genvar g = 0; g < RATIO; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                data[g*STR_W +: STR_W] <= '0;
                strb[g*STR_B +: STR_B] <= '0;
            end else if (wr_en && (lane_sel == LANE_W'(g))) begin
                data[g*STR_W +: STR_W] <= din;
                strb[g*STR_B +: STR_B] <= '1;
            end
        end
    end
endmodule

// File: rtl/s2m_pack.sv
module s2m_pack
    import s2m_pack_pkg::*;
#(
    parameter int MEM_W  = 64,
    parameter int STR_W  = 16,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic [LEN_W-1:0]   cmd_len,
    output logic               cmd_err,
    input  logic               s_valid,
    output logic               s_ready,
    input  logic [STR_W-1:0]   s_data,
    output logic               m_valid,
    input  logic               m_ready,
    output logic [MEM_W-1:0]   m_data,
    output logic [MEM_W/8-1:0] m_strb,
    output logic               m_last
);
    localparam int RATIO  = MEM_W / STR_W;
    localparam int MEM_B  = MEM_W / 8;
    localparam int STR_B  = STR_W / 8;
    localparam int LANE_W = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam int STR_SH = (STR_B > 1) ? $clog2(STR_B) : 0;

    pack_state_t       state, state_nx;
    logic [LANE_W-1:0] lane;
    logic [LEN_W-1:0]  words_left;
    logic              last_q;
    logic              err_q;
    logic              cmd_ok;
    logic              cmd_fire, s_fire, m_fire;
    logic              buf_clr;
    logic              beat_done;

    s2m_cmd_check #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MEM_B(MEM_B), .STR_B(STR_B)
    ) u_check (
        .addr (cmd_addr),
        .len  (cmd_len),
        .ok   (cmd_ok)
    );

    s2m_lane_buf #(
        .STR_W(STR_W), .RATIO(RATIO), .LANE_W(LANE_W)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (buf_clr),
        .wr_en    (s_fire),
        .lane_sel (lane),
        .din      (s_data),
        .data     (m_data),
        .strb     (m_strb)
    );

    // Outputs decoded from state
    always_comb begin
        cmd_ready = (state == ST_IDLE);
        s_ready   = (state == ST_FILL);
        m_valid   = (state == ST_SEND);
        m_last    = (state == ST_SEND) && last_q;
        cmd_err   = err_q;
        cmd_fire  = cmd_valid && cmd_ready;
        s_fire    = s_valid && s_ready;
        m_fire    = m_valid && m_ready;
        beat_done = (lane == LANE_W'(RATIO - 1)) || (words_left == LEN_W'(1));
        buf_clr   = m_fire || (cmd_fire && cmd_ok);
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (cmd_fire && cmd_ok) state_nx = ST_FILL;
            ST_FILL: if (s_fire && beat_done) state_nx = ST_SEND;
            ST_SEND: if (m_fire) state_nx = last_q ? ST_IDLE : ST_FILL;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Counters and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane       <= '0;
            words_left <= '0;
            last_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            err_q <= cmd_fire && !cmd_ok;
            if (cmd_fire && cmd_ok) begin
                lane       <= '0;
                words_left <= cmd_len >> STR_SH;
                last_q     <= 1'b0;
            end
            if (s_fire) begin
                lane       <= lane + 1'b1;
                words_left <= words_left - 1'b1;
                last_q     <= (words_left == LEN_W'(1));
            end
            if (m_fire) lane <= '0;
        end
    end
endmodule

// File: rtl/s2m_pack_chk.sv
module s2m_pack_chk #(
    parameter int MEM_W = 64
)(
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic               cmd_ready,
    input logic               cmd_err,
    input logic               s_ready,
    input logic               m_valid,
    input logic               m_ready,
    input logic [MEM_W-1:0]   m_data,
    input logic [MEM_W/8-1:0] m_strb,
    input logic               m_last
);
    localparam int MEM_B = MEM_W / 8;

    logic [MEM_B:0] strb_ext;
    logic           strb_contig;
    logic           fill_bad;

    always_comb begin
        strb_ext    = {1'b0, m_strb};
        strb_contig = ((strb_ext + 1'b1) & strb_ext) == '0;
        fill_bad    = 1'b0;
        for (int i = 0; i < MEM_B; i++)
            if (!m_strb[i] && (m_data[8*i +: 8] != 8'h00)) fill_bad = 1'b1;
    end

    AST_ERR_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(cmd_valid && cmd_ready)) else $error("err without command"); // R1
    AST_ERR_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> cmd_ready && !m_valid) else $error("left idle on reject"); // R2
    AST_TAIL_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> m_strb[0] && strb_contig) else $error("strobe not contiguous"); // R3
    AST_FULL_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !m_last |-> m_strb == '1) else $error("partial non-final beat"); // R4
    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> !fill_bad) else $error("masked lane not zero"); // R5
    AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && m_ready && m_last |=> cmd_ready && !m_valid) else $error("no idle after last"); // R7
    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_strb) && $stable(m_last))
        else $error("beat changed under stall"); // R8
    AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_ready, s_ready, m_valid})) else $error("two sides open"); // R9
endmodule

bind s2m_pack s2m_pack_chk #(.MEM_W(MEM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_err   (cmd_err),
    .s_ready   (s_ready),
    .m_valid   (m_valid),
    .m_ready   (m_ready),
    .m_data    (m_data),
    .m_strb    (m_strb),
    .m_last    (m_last)
);

// File: tb/sim_s2m_pack.sv
`timescale 1ns/1ps
module sim_s2m_pack;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_addr = '0;
    logic [15:0] cmd_len = '0;
    logic        cmd_err;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [15:0] s_data = '0;
    logic        m_valid;
    logic        m_ready = 1'b0;
    logic [63:0] m_data;
    logic [7:0]  m_strb;
    logic        m_last;

    int checks = 0;
    int fails  = 0;
    logic [15:0] wd [0:255];

    always #4 clk = ~clk;

    s2m_pack u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_err(cmd_err),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
        .m_strb(m_strb), .m_last(m_last)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [63:0] exp_data(input int b, input int nw);
        logic [63:0] d = '0;
        for (int k = 0; k < 4; k++)
            if (b*4 + k < nw) d[16*k +: 16] = wd[b*4 + k];
        return d;
    endfunction

    function automatic logic [7:0] exp_strb(input int b, input int len);
        int n = len - 8*b;
        logic [8:0] one = 9'd1;
        if (n > 8) n = 8;
        return 8'((one << n) - 9'd1);
    endfunction

    task automatic do_cmd(input logic [31:0] a, input logic [15:0] l,
                          input bit bad, input string tag);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_addr = a; cmd_len = l;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_addr = $urandom; cmd_len = 16'($urandom);
        check(tag, 64'(cmd_err), 64'(bad));
        if (bad) begin
            check(tag, 64'({cmd_ready, s_ready, m_valid}), 64'b100);
            @(negedge clk);
            check(tag, 64'(cmd_err), 64'd0);
            check(tag, 64'(m_valid), 64'd0);
        end else begin
            check("R9", 64'({cmd_ready, s_ready, m_valid}), 64'b010);
        end
    endtask

    task automatic produce(input int nw);
        for (int i = 0; i < nw; i++) begin
            while ($urandom % 4 == 0) begin s_valid = 1'b0; @(negedge clk); end
            s_valid = 1'b1; s_data = wd[i];
            while (!s_ready) @(negedge clk);
            @(negedge clk);
        end
        s_valid = 1'b0;
    endtask

    task automatic consume(input int len);
        int nb = (len + 7) / 8;
        int b = 0;
        bit held = 0;
        logic [63:0] hd; logic [7:0] hs; logic hl;
        while (b < nb) begin
            @(negedge clk);
            if (held) begin
                check("R8", 64'(m_valid), 64'd1);
                check("R8", m_data, hd);
                check("R8", 64'({hl, m_strb}), 64'({hl, hs}) | 64'(m_last) << 8);
            end
            m_ready = ($urandom % 3) != 0;
            if (m_valid) begin
                check("R8", 64'(s_ready), 64'd0);
                if (m_ready) begin
                    check("R5", m_data, exp_data(b, len/2));
                    check(b == nb-1 ? "R3" : "R4", 64'(m_strb), 64'(exp_strb(b, len)));
                    check("R6", 64'(m_last), 64'(b == nb-1));
                    b++; held = 0;
                end else begin
                    held = 1; hd = m_data; hs = m_strb; hl = m_last;
                end
            end
        end
        @(negedge clk);
        m_ready = 1'b0;
        check("R7", 64'({cmd_ready, m_valid}), 64'b10);
    endtask

    task automatic run_xfer(input logic [31:0] a, input int len);
        for (int i = 0; i < len/2; i++) wd[i] = 16'($urandom);
        do_cmd(a, 16'(len), 1'b0, "R2");
        fork
            produce(len/2);
            consume(len);
        join
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R6 actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R9", 64'({cmd_ready, s_ready, m_valid, cmd_err}), 64'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", 64'({cmd_ready, s_ready, m_valid, cmd_err}), 64'b1000);

        // Directed corners
        do_cmd(32'h0000_1004, 16'd16, 1'b1, "R1");
        do_cmd(32'h0000_1002, 16'd8,  1'b1, "R1");
        do_cmd(32'h0000_2000, 16'd5,  1'b1, "R2");
        do_cmd(32'h0000_2000, 16'd0,  1'b1, "R2");
        run_xfer(32'h0000_0000, 2);
        run_xfer(32'h0000_0008, 8);
        run_xfer(32'h0000_0010, 14);
        run_xfer(32'h0000_0040, 16);
        run_xfer(32'h0000_0080, 10);
        run_xfer(32'h0000_0100, 36);

        // Constrained random mix
        for (int t = 0; t < 30; t++) begin
            if ($urandom % 5 == 0) begin
                do_cmd(($urandom & 32'hFFFF_FFF8) | 32'(1 + $urandom % 7), 16'd8, 1'b1, "R1");
            end else if ($urandom % 6 == 0) begin
                do_cmd($urandom & 32'hFFFF_FFF8, 16'(2*($urandom % 40) + 1), 1'b1, "R2");
            end else begin
                run_xfer($urandom & 32'hFFFF_FFF8, 2 * (1 + int'($urandom % 64)));
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule